// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer with 9-bit words and a parameterised depth (512 words by default). Its write side and read side run on separate clocks. The two clocks may be the same net, or they may be fully asynchronous to each other. A word is stored only when both write enables are high, and a word is taken only when both read enables are high. This lets two independent agents gate each port without extra glue logic.

Four status outputs report the fill level:
- Empty and almost-empty are produced in the read clock domain.
- Full and almost-full are produced in the write clock domain.

The two almost-thresholds are run-time programmable. While the load input is high, every enabled write cycle goes to the next threshold register in turn instead of the storage array. Reset restores both thresholds to 7. A read-side output enable floats the data output.

Top module: `dcf_top`

## Requirements
- R1: A word is stored on a rising write-clock edge only when both `wen_a_i` and `wen_b_i` are 1, `load_i` is 0 and `full_o` is 0. If either enable is 0, nothing is stored.
- R2: On a rising read-clock edge with both `ren_a_i` and `ren_b_i` at 1 and `empty_o` at 0, the oldest stored word is loaded into the output register and removed. Words leave in the order they were written.
- R3: A write attempted while `full_o` is 1 is ignored. The write pointer and the stored contents stay unchanged.
- R4: A read attempted while `empty_o` is 1 is ignored. The read pointer and the output register hold their values.
- R5: `empty_o` is 1 exactly when the read side sees no stored words. `full_o` is 1 exactly when the write side sees DEPTH stored words. Once both sides have settled, both flags reflect the true count.
- R6: `aempty_o` is 1 when the word count seen by the read side is less than or equal to the almost-empty offset.
- R7: `afull_o` is 1 when the word count seen by the write side is at least DEPTH minus the almost-full offset.
- R8: While `load_i` is 1, each write cycle with both enables at 1 copies the low log2(DEPTH) bits of `din_i` into one offset register. The first such cycle loads the almost-empty offset and the second loads the almost-full offset. The sequence then wraps back to the almost-empty offset. These cycles do not touch the array or the write pointer.
- R9: When `oe_i` is 0, `dout_o` is high impedance. When `oe_i` is 1, `dout_o` shows the output register.
- R10: While `rst_ni` is 0, the block is held in reset. Reset clears both pointers and sets `empty_o`=1, `aempty_o`=1, `full_o`=0 and `afull_o`=0. It also sets both offsets back to 7, returns the load sequence to the almost-empty offset, and clears the output register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_a_i | input | 1 | Write enable, first qualifier |
| wen_b_i | input | 1 | Write enable, second qualifier |
| load_i | input | 1 | Steers enabled writes into the offset registers |
| din_i | input | 9 | Write data, or offset value during a load |
| ren_a_i | input | 1 | Read enable, first qualifier |
| ren_b_i | input | 1 | Read enable, second qualifier |
| oe_i | input | 1 | Output enable; 0 floats the data output |
| dout_o | output | 9 | Read data |
| empty_o | output | 1 | No words stored (read domain) |
| aempty_o | output | 1 | Count at or below the almost-empty offset (read domain) |
| afull_o | output | 1 | Count at or above DEPTH minus the almost-full offset (write domain) |
| full_o | output | 1 | DEPTH words stored (write domain) |

## Verification
Assertions on every cycle check four properties:
- A write attempt while full leaves the write pointer still.
- A read attempt while empty leaves the read pointer still.
- An offset-load cycle never moves the write pointer.
- Full always implies almost-full, and empty always implies almost-empty.

Some behaviours can only be shown by the bench's scenarios:
- The data ordering and the values of the flag thresholds, both the defaults and the loaded values.
- The wrap of the load sequence.
- The high-impedance output.
- The effect of a mid-run reset on the offsets.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W  = 9;
  localparam int NUM_OFS = 2;
  localparam int OFS_AE  = 0;  // load order: almost-empty first
  localparam int OFS_AF  = 1;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter  int DEPTH = 512,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl import dcf_pkg::*; #(
  parameter  int DEPTH   = 512,
  parameter  int DEF_OFS = 7,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1,
  localparam int OW      = AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_a_i,
  input  logic              wen_b_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [PW-1:0]     rgray_i,   // synchronised read pointer
  output logic [PW-1:0]     wgray_o,
  output logic [AW-1:0]     waddr_o,
  output logic              mem_we_o,
  output logic [OW-1:0]     ae_ofs_o,
  output logic              full_o,
  output logic              afull_o
);
  localparam int SEL_W = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1;

  logic          we, ld, push;
  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, used;
  logic [SEL_W-1:0] sel_q;
  logic [OW-1:0] ofs_q [NUM_OFS];

  assign we   = wen_a_i & wen_b_i;
  assign ld   = we & load_i;
  assign push = we & ~load_i & ~full_o;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_i >> i);
  end

  assign wbin_nxt = wbin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  // offset load sequencer, wraps after last register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         sel_q <= '0;
    else if (ld && sel_q == SEL_W'(NUM_OFS - 1)) sel_q <= '0;
    else if (ld)                         sel_q <= sel_q + SEL_W'(1);
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ofs_q[g] <= OW'(DEF_OFS);
      else if (ld && sel_q == SEL_W'(g))    ofs_q[g] <= OW'(din_i);
    end
  end

  assign full_o   = (wgray_q == {~rgray_i[PW-1:PW-2], rgray_i[PW-3:0]});
  assign used     = wbin_q - rbin_s;
  assign afull_o  = (used >= (PW'(DEPTH) - PW'(ofs_q[OFS_AF])));
  assign ae_ofs_o = ofs_q[OFS_AE];
  assign wgray_o  = wgray_q;
  assign waddr_o  = wbin_q[AW-1:0];
  assign mem_we_o = push;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && !load_i && full_o) |=> $stable(wbin_q)); // R3
  AST_LOAD_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> $stable(wbin_q)); // R8
  AST_FULL_IN_AFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> afull_o); // R7
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int OW    = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_a_i,
  input  logic          ren_b_i,
  input  logic [PW-1:0] wgray_i,   // synchronised write pointer
  input  logic [OW-1:0] ae_ofs_i,  // quasi-static, changed only while idle
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          pop_o,
  output logic          empty_o,
  output logic          aempty_o
);
  logic          re, pop;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_s, used;

  assign re  = ren_a_i & ren_b_i;
  assign pop = re & ~empty_o;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_i >> i);
  end

  assign rbin_nxt = rbin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign empty_o  = (rgray_q == wgray_i);
  assign used     = wbin_s - rbin_q;
  assign aempty_o = (used <= PW'(ae_ofs_i));
  assign rgray_o  = rgray_q;
  assign raddr_o  = rbin_q[AW-1:0];
  assign pop_o    = pop;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re && empty_o) |=> $stable(rbin_q)); // R4
  AST_EMPTY_IN_AEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o); // R6
endmodule

// File: rtl/dcf_top.sv
module dcf_top import dcf_pkg::*; #(
  parameter  int DEPTH   = 512,
  parameter  int DEF_OFS = 7,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_a_i,
  input  logic              wen_b_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren_a_i,
  input  logic              ren_b_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              afull_o,
  output logic              full_o
);
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  logic [AW-1:0]     waddr, raddr;
  logic [AW-1:0]     ae_ofs;
  logic              mem_we, pop;
  logic [DATA_W-1:0] rdata;

  dcf_wr_ctrl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) i_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_a_i(wen_a_i), .wen_b_i(wen_b_i),
    .load_i(load_i), .din_i(din_i), .rgray_i(rgray_ws), .wgray_o(wgray),
    .waddr_o(waddr), .mem_we_o(mem_we), .ae_ofs_o(ae_ofs),
    .full_o(full_o), .afull_o(afull_o)
  );

  dcf_sync #(.W(PW)) i_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  dcf_sync #(.W(PW)) i_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH)) i_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren_a_i(ren_a_i), .ren_b_i(ren_b_i),
    .wgray_i(wgray_rs), .ae_ofs_i(ae_ofs), .rgray_o(rgray), .raddr_o(raddr),
    .pop_o(pop), .empty_o(empty_o), .aempty_o(aempty_o)
  );

  dcf_mem #(.DEPTH(DEPTH), .DW(DATA_W)) i_mem (
    .wclk_i(wclk_i), .we_i(mem_we), .waddr_i(waddr), .wdata_i(din_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .re_i(pop), .raddr_i(raddr),
    .rdata_o(rdata)
  );

  assign dout_o = oe_i ? rdata : 'z;
endmodule

// File: tb/test_dcf_top.sv
module test_dcf_top;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 16;
  localparam int NV          = 8;
  // per vector: writes, reads, expected {empty, aempty, afull, full}
  localparam int          VW [NV] = '{3, 5, 1, 7, 2,  0, 0, 0};
  localparam int          VR [NV] = '{0, 0, 0, 0, 0, 10, 6, 2};
  localparam logic [3:0]  VF [NV] = '{4'b0100, 4'b0000, 4'b0010, 4'b0011,
                                      4'b0011,  // R3 writes while full
                                      4'b0100, 4'b1100,
                                      4'b1100}; // R4 reads while empty

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen_a = 0, wen_b = 0, load = 0, ren_a = 0, ren_b = 0, oe = 1;
  logic [8:0] din = 0;
  wire  [8:0] dout;
  logic empty, aempty, afull, full;

  int total = 0, bad = 0;
  bit done = 0;
  logic [8:0] model [$];
  logic [8:0] last_q = 0;
  logic [8:0] wdat = 9'h10;

  always #(CLK_PERIOD / 2)  wclk = ~wclk;
  always #(RCLK_PERIOD / 2) rclk = ~rclk;

  dcf_top #(.DEPTH(DEPTH)) i_dcf_top (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wen_a_i(wen_a),
    .wen_b_i(wen_b), .load_i(load), .din_i(din), .ren_a_i(ren_a),
    .ren_b_i(ren_b), .oe_i(oe), .dout_o(dout), .empty_o(empty),
    .aempty_o(aempty), .afull_o(afull), .full_o(full)
  );

  task automatic chk_flags(input string req, input logic [3:0] exp);
    total++;
    if ({empty, aempty, afull, full} !== exp) begin
      bad++;
      $display("FAIL %s flags {e,ae,af,f} act=%b exp=%b", req,
               {empty, aempty, afull, full}, exp);
    end
  endtask

  task automatic chk_data(input string req, input logic [8:0] exp);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s dout act=%h exp=%h", req, dout, exp);
    end
  endtask

  task automatic wr(input logic [8:0] d, input bit ld, input bit a = 1, input bit b = 1);
    @(negedge wclk);
    din = d; load = ld; wen_a = a; wen_b = b;
    @(negedge wclk);
    wen_a = 0; wen_b = 0; load = 0;
    if (a && b && !ld && model.size() < DEPTH) model.push_back(d);
  endtask

  task automatic wr_n(input int n);
    for (int k = 0; k < n; k++) begin
      wr(wdat, 0);
      wdat++;
    end
  endtask

  task automatic rd(input string req);
    logic [8:0] exp;
    @(negedge rclk);
    ren_a = 1; ren_b = 1;
    @(negedge rclk);
    ren_a = 0; ren_b = 0;
    if (model.size() > 0) exp = model.pop_front();
    else exp = last_q;
    last_q = exp;
    chk_data(req, exp);
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    model.delete();
    last_q = 0;
    settle();
  endtask

  initial begin
    do_reset();
    chk_flags("R10 reset flags", 4'b1100);
    chk_data("R10 reset dout", 9'h000);
    oe = 0;
    #1;
    total++;
    if (dout !== 9'bz) begin
      bad++;
      $display("FAIL R9 dout act=%h exp=zzz", dout);
    end
    oe = 1;
    #1;
    chk_data("R9 oe restored", 9'h000);

    // R1: a single enable stores nothing
    wr(9'h055, 0, 1, 0);
    wr(9'h066, 0, 0, 1);
    settle();
    chk_flags("R1 one enable only", 4'b1100);

    // table walk, R2 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr_n(VW[i]);
      for (int k = 0; k < VR[i]; k++) rd("R2 order");
      settle();
      chk_flags($sformatf("R5 R6 R7 vector %0d", i), VF[i]);
    end

    // R8: three loads, third wraps back to almost-empty offset
    wr(9'd9, 1);
    wr(9'd3, 1);
    wr(9'd5, 1);
    settle();
    chk_flags("R8 load leaves array empty", 4'b1100);
    wr_n(5);
    settle();
    chk_flags("R8 count5 ae ofs5", 4'b0100);
    wr_n(1);
    settle();
    chk_flags("R8 count6 ae ofs5", 4'b0000);
    wr_n(6);
    settle();
    chk_flags("R8 count12 af ofs3", 4'b0000);
    wr_n(1);
    settle();
    chk_flags("R8 count13 af ofs3", 4'b0010);
    for (int k = 0; k < 13; k++) rd("R2 drain");
    settle();
    chk_flags("R5 drained", 4'b1100);

    // R10: reset restores default offsets
    do_reset();
    chk_data("R10 dout cleared", 9'h000);
    wr_n(7);
    settle();
    chk_flags("R10 default ae at 7", 4'b0100);
    wr_n(1);
    settle();
    chk_flags("R10 default ae off at 8", 4'b0000);
    wr_n(1);
    settle();
    chk_flags("R10 default af at 9", 4'b0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule